// File: doc/BRIEF.md
# AXI4-Lite Field Register Bank

This block is a small bank of 32-bit registers. A CPU reaches it over an AXI4-Lite subordinate port. Each register is made of fields packed upward from bit 0, and every field has one access mode:

- constant or status read-only
- read-write control
- sticky event that clears when read
- write-one command strobe

Status inputs from the surrounding core are read through a read-only word. Control fields drive outputs into the core. Sticky fields catch event pulses from the core. Command fields emit single-cycle strobes.

The event word is flagged as an interrupt source. A level interrupt output is high while any of its sticky bits is set. The CPU services it by reading the event word, and that read returns the pending bits and clears them.

Internally the bank decodes word addresses. The AXI byte address is the word index shifted left by two, and the two low address bits are ignored.

Top module: `regbank_axil`

## Requirements
- R1: After reset `core_hold` is 1, `gain` equals `GAIN_RST` (default 0x10), `irq` is 0, `cmd_pulse` is 0, and neither `s_bvalid` nor `s_rvalid` is asserted.
- R2: Word 0 (byte address 0x00) always reads the constant `ID_VALUE` (default 0x6169616D).
- R3: Word 1 (byte 0x04) reads `status_in` in bits [STAT_W-1:0], with the bits above it zero.
- R4: Word 2 (byte 0x08) is read-write. Bit 0 drives `core_hold` and bits [GAIN_W:1] drive `gain`. A write changes only the bits whose byte lane has its `s_wstrb` bit set (bits 7:0 are lane 0, bit 8 is lane 1), and a read returns the stored value.
- R5: In word 3 (byte 0x0C), bit i is set in the cycle after `event_in[i]` is high. It stays set after `event_in[i]` returns to 0.
- R6: A read of word 3 returns the sticky bits and clears them. If `event_in[i]` is high in the cycle of that read, bit i stays set.
- R7: `irq` is high exactly while at least one bit of word 3 is set.
- R8: Writing 1 to bit i of word 4 (byte 0x10) gives a single-cycle high pulse on `cmd_pulse[i]`, independent of the strobes. Writing 0 gives no pulse, and reading word 4 returns 0.
- R9: Words 5 to 7 read as 0 with an OKAY response. Writes to words 0, 1, 3 and the unmapped words change no readable state and no output.
- R10: A write takes effect only after both the address and the data handshakes have completed, in either order. One transaction of each direction is in flight at a time, and `s_bresp` and `s_rresp` are always OKAY (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | AW | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | AW | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| status_in | input | STAT_W | Core status shown in word 1 |
| event_in | input | EVT_W | Core event pulses latched in word 3 |
| core_hold | output | 1 | Core reset control, word 2 bit 0 |
| gain | output | GAIN_W | Control field, word 2 bits [GAIN_W:1] |
| cmd_pulse | output | CMD_W | Command strobes from word 4 |
| irq | output | 1 | Level interrupt, any event bit set |

## Verification
The results arrive at fixed distances from a stimulus:

- **Reads:** read data appears in the cycle after the read address handshake.
- **Writes:** control outputs, command strobes and the write response all change one edge after the later of the two write handshakes.
- **Events:** a sticky bit, and so `irq`, follows its event input by one edge.

Read expectations are queued by the issuing task and popped by a monitor on the falling edge where `s_rvalid` is seen. Strobes and control outputs are sampled on the falling edge after the write edge, and again one cycle later, to prove the pulse lasted exactly one cycle. The event-during-read case drives the event in the very cycle of the read handshake, so the set and the clear meet on the same edge.

// File: rtl/regbank_axil.sv
module regbank_axil #(
  parameter int AW       = 5,
  parameter logic [31:0] ID_VALUE = 32'h6169616D,
  parameter int STAT_W   = 16,
  parameter int EVT_W    = 2,
  parameter int GAIN_W   = 8,
  parameter int GAIN_RST = 16,
  parameter int CMD_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [AW-1:0]     s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic [STAT_W-1:0] status_in,
  input  logic [EVT_W-1:0]  event_in,
  output logic              core_hold,
  output logic [GAIN_W-1:0] gain,
  output logic [CMD_W-1:0]  cmd_pulse,
  output logic              irq
);
  localparam int WA = AW - 2;
  localparam int CTRL_W = GAIN_W + 1;
  localparam logic [WA-1:0] A_ID = WA'(0);
  localparam logic [WA-1:0] A_STAT = WA'(1);
  localparam logic [WA-1:0] A_CTRL = WA'(2);
  localparam logic [WA-1:0] A_EVT = WA'(3);
  localparam logic [WA-1:0] A_CMD = WA'(4);
  localparam logic [CTRL_W-1:0] CTRL_RST = {GAIN_W'(GAIN_RST), 1'b1};

  logic          aw_got, w_got;
  logic [WA-1:0] aw_word;
  logic [31:0]   wdata_q;
  logic [3:0]    wstrb_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [EVT_W-1:0]  sticky_q;
  logic [31:0]   rd_mux;

  wire [WA-1:0] ar_word = s_araddr[AW-1:2];
  wire aw_hs  = s_awvalid & s_awready;
  wire w_hs   = s_wvalid & s_wready;
  wire ar_hs  = s_arvalid & s_arready;
  wire do_wr  = aw_got & w_got & ~s_bvalid;
  wire rd_evt = ar_hs & (ar_word == A_EVT);
  wire unused_ok = ^{s_awaddr[1:0], s_araddr[1:0], wdata_q, wstrb_q};

  assign s_awready = ~aw_got & ~s_bvalid;
  assign s_wready  = ~w_got & ~s_bvalid;
  assign s_arready = ~s_rvalid;
  assign s_bresp   = 2'b00;
  assign s_rresp   = 2'b00;
  assign core_hold = ctrl_q[0];
  assign gain      = ctrl_q[CTRL_W-1:1];
  assign irq       = |sticky_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_got   <= 1'b0;
      w_got    <= 1'b0;
      aw_word  <= '0;
      wdata_q  <= '0;
      wstrb_q  <= '0;
      s_bvalid <= 1'b0;
    end else begin
      if (aw_hs) begin
        aw_got  <= 1'b1;
        aw_word <= s_awaddr[AW-1:2];
      end
      if (w_hs) begin
        w_got   <= 1'b1;
        wdata_q <= s_wdata;
        wstrb_q <= s_wstrb;
      end
      if (do_wr) begin
        aw_got   <= 1'b0;
        w_got    <= 1'b0;
        s_bvalid <= 1'b1;
      end else if (s_bvalid && s_bready) begin
        s_bvalid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else if (do_wr && aw_word == A_CTRL) begin
      for (int i = 0; i < CTRL_W; i++)
        if (wstrb_q[i/8]) ctrl_q[i] <= wdata_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_pulse <= '0;
    else        cmd_pulse <= (do_wr && aw_word == A_CMD) ? wdata_q[CMD_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= (sticky_q & ~{EVT_W{rd_evt}}) | event_in;
  end

  always_comb begin
    case (ar_word)
      A_ID:    rd_mux = ID_VALUE;
      A_STAT:  rd_mux = 32'(status_in);
      A_CTRL:  rd_mux = 32'(ctrl_q);
      A_EVT:   rd_mux = 32'(sticky_q);
      default: rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else if (ar_hs) begin
      s_rvalid <= 1'b1;
      s_rdata  <= rd_mux;
    end else if (s_rready) begin
      s_rvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/regbank_axil_chk.sv
module regbank_axil_chk #(
  parameter int AW    = 5,
  parameter int EVT_W = 2,
  parameter int CMD_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CMD_W-1:0] cmd_pulse,
  input logic             irq,
  input logic [EVT_W-1:0] event_in,
  input logic             core_hold,
  input logic             s_bvalid,
  input logic [1:0]       s_bresp,
  input logic [1:0]       s_rresp,
  input logic             s_rvalid,
  input logic             s_rready,
  input logic [31:0]      s_rdata,
  input logic             s_arvalid,
  input logic             s_arready,
  input logic [AW-1:0]    s_araddr
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_pulse) |=> (cmd_pulse == '0)); // R8
  AST_EVENT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|event_in) |=> irq); // R5
  AST_IRQ_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(s_arvalid && s_arready && ((s_araddr >> 2) == 3))); // R6
  AST_CTRL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(core_hold) |-> $rose(s_bvalid)); // R4
  AST_RESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid || s_rvalid) |-> (s_bresp == 2'b00 && s_rresp == 2'b00)); // R10
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata))); // R10
endmodule

bind regbank_axil regbank_axil_chk #(.AW(AW), .EVT_W(EVT_W), .CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_pulse(cmd_pulse), .irq(irq), .event_in(event_in),
  .core_hold(core_hold), .s_bvalid(s_bvalid), .s_bresp(s_bresp), .s_rresp(s_rresp),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
  .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr));

// File: tb/regbank_axil_bench.sv
module regbank_axil_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [4:0] s_awaddr = 0, s_araddr = 0;
  logic s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 1;
  logic [31:0] s_wdata = 0;
  logic [3:0] s_wstrb = 0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0] s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [15:0] status_in = 16'hBEEF;
  logic [1:0] event_in = 0;
  logic core_hold, irq;
  logic [7:0] gain;
  logic [1:0] cmd_pulse;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [8:0] ctrl_m = {8'h10, 1'b1};
  logic [1:0] pulse_at, pulse_after;

  always #(CLK_PERIOD/2) clk = ~clk;

  regbank_axil u_regbank_axil (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  always @(negedge clk) if (s_rvalid) begin
    if (exp_q.size() == 0) chk("R10 unexpected rvalid", 32'd1, 32'd0);
    else begin
      string t;
      logic [31:0] e;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      chk(t, s_rdata, e);
      chk({t, " rresp"}, {30'd0, s_rresp}, 32'd0);
    end
  end

  task automatic axi_read(logic [4:0] a, logic [31:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk); s_araddr = a; s_arvalid = 1;
    @(posedge clk);
    @(negedge clk); s_arvalid = 0;
    @(negedge clk);
  endtask

  task automatic axi_write(logic [4:0] a, logic [31:0] d, logic [3:0] s);
    @(negedge clk); s_awaddr = a; s_wdata = d; s_wstrb = s; s_awvalid = 1; s_wvalid = 1;
    @(posedge clk);
    @(negedge clk); s_awvalid = 0; s_wvalid = 0;
    @(posedge clk);
    @(negedge clk); pulse_at = cmd_pulse;
    chk("R10 bvalid after write", {31'd0, s_bvalid}, 32'd1);
    chk("R10 bresp okay", {30'd0, s_bresp}, 32'd0);
    @(negedge clk); pulse_after = cmd_pulse;
  endtask

  function automatic logic [8:0] merge(logic [8:0] old, logic [31:0] d, logic [3:0] s);
    logic [8:0] m;
    m = {s[1], {8{s[0]}}};
    return (old & ~m) | (d[8:0] & m);
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 core_hold", {31'd0, core_hold}, 32'd1);
    chk("R1 gain", {24'd0, gain}, 32'h10);
    chk("R1 irq/pulse/valid", {27'd0, irq, cmd_pulse, s_bvalid, s_rvalid}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    axi_read(5'h00, 32'h6169616D, "R2 id word");
    axi_read(5'h04, 32'h0000BEEF, "R3 status");
    status_in = 16'h1234;
    axi_read(5'h04, 32'h00001234, "R3 status updated");
    axi_read(5'h08, {23'd0, ctrl_m}, "R4 ctrl reset readback");

    axi_write(5'h08, 32'h0, 4'hF);
    ctrl_m = merge(ctrl_m, 32'h0, 4'hF);
    chk("R4 core_hold released", {31'd0, core_hold}, 32'd0);
    chk("R4 gain cleared", {24'd0, gain}, 32'd0);
    axi_write(5'h08, 32'h0000_01FF, 4'b0001);
    ctrl_m = merge(ctrl_m, 32'h01FF, 4'b0001);
    axi_read(5'h08, {23'd0, ctrl_m}, "R4 lane0 only");
    chk("R4 gain port lane0", {24'd0, gain}, {24'd0, ctrl_m[8:1]});
    axi_write(5'h08, 32'h0000_0100, 4'b0010);
    ctrl_m = merge(ctrl_m, 32'h0100, 4'b0010);
    axi_read(5'h0B, {23'd0, ctrl_m}, "R4 lane1, low addr bits ignored");

    axi_write(5'h10, 32'h2, 4'h0);
    chk("R8 pulse bit1", {30'd0, pulse_at}, 32'd2);
    chk("R8 pulse one cycle", {30'd0, pulse_after}, 32'd0);
    axi_write(5'h10, 32'h0, 4'hF);
    chk("R8 zero write no pulse", {30'd0, pulse_at}, 32'd0);
    axi_read(5'h10, 32'h0, "R8 cmd reads zero");

    @(negedge clk); event_in = 2'b01;
    @(negedge clk); event_in = 2'b00;
    chk("R7 irq after event", {31'd0, irq}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R5 sticky holds irq", {31'd0, irq}, 32'd1);
    axi_read(5'h0C, 32'h1, "R5 sticky bit0 read");
    chk("R6 cleared by read", {31'd0, irq}, 32'd0);
    axi_read(5'h0C, 32'h0, "R6 reads zero after clear");

    @(negedge clk); event_in = 2'b10; s_araddr = 5'h0C; s_arvalid = 1;
    exp_q.push_back(32'h0); tag_q.push_back("R6 read during event");
    @(posedge clk);
    @(negedge clk); event_in = 2'b00; s_arvalid = 0;
    chk("R6 set beats clear", {31'd0, irq}, 32'd1);
    @(negedge clk);
    axi_read(5'h0C, 32'h2, "R6 event kept");

    axi_write(5'h00, 32'hFFFF_FFFF, 4'hF);
    axi_write(5'h0C, 32'h3, 4'hF);
    axi_write(5'h14, 32'hFFFF_FFFF, 4'hF);
    chk("R9 ignored writes no pulse/irq", {29'd0, irq, pulse_at}, 32'd0);
    axi_read(5'h00, 32'h6169616D, "R9 id unchanged");
    axi_read(5'h0C, 32'h0, "R9 sticky unchanged by write");
    axi_read(5'h14, 32'h0, "R9 unmapped 5");
    axi_read(5'h1C, 32'h0, "R9 unmapped 7");

    @(negedge clk); s_wdata = 32'h1; s_wstrb = 4'h1; s_wvalid = 1;
    @(posedge clk);
    @(negedge clk); s_wvalid = 0;
    repeat (3) @(negedge clk);
    chk("R10 no write before address", {30'd0, s_bvalid, core_hold}, {30'd0, 1'b0, ctrl_m[0]});
    s_awaddr = 5'h08; s_awvalid = 1;
    @(posedge clk);
    @(negedge clk); s_awvalid = 0;
    ctrl_m = merge(ctrl_m, 32'h1, 4'h1);
    @(negedge clk);
    chk("R10 write after both handshakes", {31'd0, core_hold}, {31'd0, ctrl_m[0]});
    axi_read(5'h08, {23'd0, ctrl_m}, "R10 data-first write stored");

    repeat (3) @(negedge clk);
    chk("R10 queue drained", exp_q.size(), 32'd0);
    finish_up();
  end
endmodule